// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Trigger-Synchronized Register Update

This block is a pulse-width modulation timer whose counter sweeps up from a start value to a period value and back down again, giving center-aligned pulses on a set of channels. Software never writes the live timing registers directly. It writes into shadow copies, and a rising edge on a hardware trigger input moves the shadow contents into the live copies. A configuration register sets which register groups take part in that move and when the move happens.

The live registers fall into two groups with different timing. Output masking, output inversion and the per-channel software override take their new values as soon as the trigger edge is seen. The period, start value and channel compare values take theirs at the next enabled turnaround of the counter, either the bottom (start value) or the top (period). A restart-on-trigger option instead loads them at the trigger edge and puts the counter back at the start value. A masked channel is cleared, but the compare logic keeps running on the live compare value. If the mask is lifted before a new compare value has loaded, the old compare value shapes the next pulse.

Top module: `pwm_sync_timer`

## Requirements
- R1: After reset the counter, the period, the start value and every compare value, both live and shadow, are zero. The mask, live and shadow, is all ones, so every output is 0.
- R2: The counter counts up by one per clock until it equals the period, then counts down by one until it equals the start value, then up again. If the period is not above the start value, the counter holds at the start value.
- R3: A write with `wr_en` high at address 0 sets the configuration: bit0 load at bottom, bit1 load at top, bit2 restart on trigger, bit3 override group enable, bit4 inversion group enable, bit5 mask group enable, bit6 buffered group enable. Address 1 writes the period shadow, address 2 the start shadow, address 3 the mask shadow, address 4 the inversion shadow, address 5 the override-enable shadow, address 6 the override-value shadow, and address 8+n the compare shadow of channel n; the per-channel registers use bit n for channel n. No write changes a live register or an output by itself.
- R4: A synchronization starts only on a low-to-high change of `hw_trig`. Holding it high starts nothing further.
- R5: On a trigger edge, each immediate group (mask, inversion, override enable and value) whose enable bit is set copies its shadow into its live register, effective on the next clock cycle.
- R6: With the buffered group enabled, a trigger edge marks a pending load. The period, start and compare shadows are then copied at the first clock where the counter equals the start value (bottom loading enabled) or the period (top loading enabled), and the pending mark clears.
- R7: With no loading point enabled and restart off, a pending buffered load never takes place.
- R8: With restart on, a trigger edge sets the counter to the start value and, if the buffered group is enabled, copies the buffered shadows in the same clock. That start value is the new one, and any pending load is cleared.
- R9: A group whose enable bit is clear keeps its live values across trigger edges.
- R10: Output n is (counter < live compare n), XOR inversion bit n. It is then replaced by the override value when override n is enabled, and forced to 0 when mask bit n is set.
- R11: Lifting the mask before a new compare value has loaded makes the channel follow the old live compare value until the buffered load occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| hw_trig | input | 1 | Hardware synchronization trigger, edge sensitive |
| pwm_out | output | 2 | Channel outputs |

## Verification
The hardest condition to reach from the ports is the window in which the mask is already lifted but the compare value is still the old one. This needs a trigger whose immediate group loads at once while its buffered group waits for the counter's top. The stimulus first masks a channel, then writes a far larger compare value and a cleared mask while only top loading is enabled. It fires the trigger partway through an upward sweep, so the old pulse appears before the new value takes over. A behavioural model that tracks the counter, the pending mark and both register copies predicts every output bit on every clock.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

   // Configuration word; bit0 is ld_bottom, bit6 is en_buf.
   typedef struct packed {
      logic en_buf;
      logic en_mask;
      logic en_inv;
      logic en_ovr;
      logic restart;
      logic ld_top;
      logic ld_bottom;
   } cfg_t;

   localparam int CFG_W       = $bits(cfg_t);
   localparam int ADR_CFG     = 0;
   localparam int ADR_PERIOD  = 1;
   localparam int ADR_START   = 2;
   localparam int ADR_MASK    = 3;
   localparam int ADR_INV     = 4;
   localparam int ADR_OVR_EN  = 5;
   localparam int ADR_OVR_VAL = 6;
   localparam int ADR_CMP0    = 8;

endpackage

// File: rtl/pwm_trig_edge.sv
module pwm_trig_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_rise
);

   logic trig_d;

   always_ff @(posedge clk) begin
      if (!rst_n) trig_d <= 1'b0;
      else        trig_d <= trig_in;
   end

   assign trig_rise = trig_in & ~trig_d;

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] start,
   input  logic             force_en,
   input  logic [CNT_W-1:0] force_val,
   output logic [CNT_W-1:0] cnt,
   output logic             at_bottom,
   output logic             at_top
);

   logic going_up;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         going_up <= 1'b1;
      end else if (force_en) begin
         cnt      <= force_val;
         going_up <= 1'b1;
      end else if (period <= start) begin
         cnt      <= start;
         going_up <= 1'b1;
      end else if (going_up) begin
         if (cnt >= period) begin
            cnt      <= cnt - 1'b1;
            going_up <= 1'b0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt <= start) begin
            cnt      <= cnt + 1'b1;
            going_up <= 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign at_bottom = (cnt == start);
   assign at_top    = (cnt == period);

endmodule

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
   import pwm_sync_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [CNT_W-1:0]             wr_data,
   input  logic                         trig_rise,
   input  logic                         at_bottom,
   input  logic                         at_top,
   output cfg_t                         cfg_q,
   output logic [CNT_W-1:0]             act_period,
   output logic [CNT_W-1:0]             act_start,
   output logic [NUM_CH-1:0][CNT_W-1:0] act_cmp,
   output logic [NUM_CH-1:0]            act_mask,
   output logic [NUM_CH-1:0]            act_inv,
   output logic [NUM_CH-1:0]            act_ovr_en,
   output logic [NUM_CH-1:0]            act_ovr_val,
   output logic [NUM_CH-1:0]            sh_mask,
   output logic                         pending,
   output logic                         cnt_force,
   output logic [CNT_W-1:0]             cnt_force_val
);

   logic [CNT_W-1:0]  sh_period, sh_start;
   logic [NUM_CH-1:0] sh_inv, sh_ovr_en, sh_ovr_val;
   logic              load_point, buf_load, restart_hit;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
      return wr_en && (a == ADDR_W'(target));
   endfunction

   assign load_point    = (cfg_q.ld_bottom && at_bottom) || (cfg_q.ld_top && at_top);
   assign restart_hit   = trig_rise && cfg_q.restart;
   assign buf_load      = (pending && load_point) || (restart_hit && cfg_q.en_buf);
   assign cnt_force     = restart_hit;
   assign cnt_force_val = cfg_q.en_buf ? sh_start : act_start;

   // Configuration and pending mark
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         pending <= 1'b0;
      end else begin
         if (hit(wr_addr, ADR_CFG)) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
         if (trig_rise && cfg_q.en_buf && !cfg_q.restart) pending <= 1'b1;
         else if (buf_load)                                pending <= 1'b0;
      end
   end

   // Buffered group: period and start
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_period  <= '0;
         sh_start   <= '0;
         act_period <= '0;
         act_start  <= '0;
      end else begin
         if (buf_load) begin
            act_period <= sh_period;
            act_start  <= sh_start;
         end
         if (hit(wr_addr, ADR_PERIOD)) sh_period <= wr_data;
         if (hit(wr_addr, ADR_START))  sh_start  <= wr_data;
      end
   end

   // Buffered group: per-channel compare values
   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
      logic [CNT_W-1:0] sh_cmp;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sh_cmp      <= '0;
            act_cmp[ch] <= '0;
         end else begin
            if (buf_load)                    act_cmp[ch] <= sh_cmp;
            if (hit(wr_addr, ADR_CMP0 + ch)) sh_cmp      <= wr_data;
         end
      end
   end

   // Immediate group: mask, inversion, override
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_mask     <= '1;
         act_mask    <= '1;
         sh_inv      <= '0;
         act_inv     <= '0;
         sh_ovr_en   <= '0;
         act_ovr_en  <= '0;
         sh_ovr_val  <= '0;
         act_ovr_val <= '0;
      end else begin
         if (trig_rise && cfg_q.en_mask) act_mask <= sh_mask;
         if (trig_rise && cfg_q.en_inv)  act_inv  <= sh_inv;
         if (trig_rise && cfg_q.en_ovr) begin
            act_ovr_en  <= sh_ovr_en;
            act_ovr_val <= sh_ovr_val;
         end
         if (hit(wr_addr, ADR_MASK))    sh_mask    <= wr_data[NUM_CH-1:0];
         if (hit(wr_addr, ADR_INV))     sh_inv     <= wr_data[NUM_CH-1:0];
         if (hit(wr_addr, ADR_OVR_EN))  sh_ovr_en  <= wr_data[NUM_CH-1:0];
         if (hit(wr_addr, ADR_OVR_VAL)) sh_ovr_val <= wr_data[NUM_CH-1:0];
      end
   end

endmodule

// File: rtl/pwm_chan_gate.sv
module pwm_chan_gate #(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2
) (
   input  logic [CNT_W-1:0]             cnt,
   input  logic [NUM_CH-1:0][CNT_W-1:0] act_cmp,
   input  logic [NUM_CH-1:0]            act_inv,
   input  logic [NUM_CH-1:0]            act_ovr_en,
   input  logic [NUM_CH-1:0]            act_ovr_val,
   input  logic [NUM_CH-1:0]            act_mask,
   output logic [NUM_CH-1:0]            pwm_out
);

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic raw, flipped, chosen;
      assign raw         = (cnt < act_cmp[ch]);
      assign flipped     = raw ^ act_inv[ch];
      assign chosen      = act_ovr_en[ch] ? act_ovr_val[ch] : flipped;
      assign pwm_out[ch] = chosen & ~act_mask[ch];
   end

endmodule

// File: rtl/pwm_sync_timer.sv
module pwm_sync_timer
   import pwm_sync_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              hw_trig,
   output logic [NUM_CH-1:0] pwm_out
);

   if (NUM_CH < 1 || ADR_CMP0 + NUM_CH > (1 << ADDR_W)) begin : g_bad_ch
      $error("pwm_sync_timer: NUM_CH does not fit the address space");
   end
   if (CNT_W < CFG_W || CNT_W < NUM_CH) begin : g_bad_w
      $error("pwm_sync_timer: CNT_W too narrow for register fields");
   end

   cfg_t                         cfg_q;
   logic                         trig_rise, at_bottom, at_top, pending;
   logic                         cnt_force;
   logic [CNT_W-1:0]             cnt, cnt_force_val, act_period, act_start;
   logic [NUM_CH-1:0][CNT_W-1:0] act_cmp;
   logic [NUM_CH-1:0]            act_mask, act_inv, act_ovr_en, act_ovr_val, sh_mask;

   pwm_trig_edge u_edge (
      .clk(clk), .rst_n(rst_n), .trig_in(hw_trig), .trig_rise(trig_rise)
   );

   pwm_updown_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .period(act_period), .start(act_start),
      .force_en(cnt_force), .force_val(cnt_force_val),
      .cnt(cnt), .at_bottom(at_bottom), .at_top(at_top)
   );

   pwm_sync_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_rise(trig_rise), .at_bottom(at_bottom), .at_top(at_top),
      .cfg_q(cfg_q), .act_period(act_period), .act_start(act_start), .act_cmp(act_cmp),
      .act_mask(act_mask), .act_inv(act_inv), .act_ovr_en(act_ovr_en),
      .act_ovr_val(act_ovr_val), .sh_mask(sh_mask), .pending(pending),
      .cnt_force(cnt_force), .cnt_force_val(cnt_force_val)
   );

   pwm_chan_gate #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_gate (
      .cnt(cnt), .act_cmp(act_cmp), .act_inv(act_inv), .act_ovr_en(act_ovr_en),
      .act_ovr_val(act_ovr_val), .act_mask(act_mask), .pwm_out(pwm_out)
   );

endmodule

// File: rtl/pwm_sync_checker.sv
module pwm_sync_checker
   import pwm_sync_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_trig,
   input logic              trig_rise,
   input logic              pending,
   input logic [CFG_W-1:0]  cfg_bits,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  act_period,
   input logic [CNT_W-1:0]  act_start,
   input logic [NUM_CH-1:0] act_mask,
   input logic [NUM_CH-1:0] sh_mask,
   input logic [NUM_CH-1:0] pwm_out
);

   cfg_t c;
   assign c = cfg_t'(cfg_bits);

   // R3: without a trigger edge or a pending load the buffered live values stay put
   assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_rise && !pending) |=> ($stable(act_period) && $stable(act_start)));

   // R4: a trigger level held high yields no further edge
   assert_level_no_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_trig && $past(hw_trig)) |-> !trig_rise);

   // R5: mask group takes the shadow right after the edge
   assert_mask_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_rise && c.en_mask) |=> (act_mask == $past(sh_mask)));

   // R7: without loading points or restart, a pending load stays pending
   assert_no_point_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !c.ld_bottom && !c.ld_top && !c.restart) |=> pending);

   // R8: restart puts the counter at the live start value
   assert_restart_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_rise && c.restart) |=> (cnt == act_start));

   // R10: a masked channel never drives high
   assert_masked_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((pwm_out & act_mask) == '0));

endmodule

bind pwm_sync_timer pwm_sync_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .trig_rise(trig_rise),
   .pending(pending), .cfg_bits(cfg_q), .cnt(cnt), .act_period(act_period),
   .act_start(act_start), .act_mask(act_mask), .sh_mask(sh_mask), .pwm_out(pwm_out)
);

// File: tb/pwm_sync_timer_tb.sv
module pwm_sync_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        hw_trig = 1'b0;
   logic [1:0]  pwm_out;

   int    vectors = 0;
   int    fails = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   pwm_sync_timer u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hw_trig(hw_trig), .pwm_out(pwm_out)
   );

   // ---------------- behavioural reference model ----------------
   int m_cnt, m_per, m_start, m_up, m_pend, m_tp, m_cfg;
   int s_per, s_start;
   int m_cmp[2];
   int s_cmp[2];
   int m_mask, m_inv, m_oe, m_ov, s_mask, s_inv, s_oe, s_ov;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_per = 0; m_start = 0; m_up = 1; m_pend = 0; m_tp = 0; m_cfg = 0;
         s_per = 0; s_start = 0;
         m_cmp[0] = 0; m_cmp[1] = 0; s_cmp[0] = 0; s_cmp[1] = 0;
         m_mask = 3; s_mask = 3; m_inv = 0; s_inv = 0;
         m_oe = 0; s_oe = 0; m_ov = 0; s_ov = 0;
      end else begin
         bit e, lp, rst_on, enbuf, ld;
         e      = hw_trig && (m_tp == 0);
         lp     = (m_cfg[0] && m_cnt == m_start) || (m_cfg[1] && m_cnt == m_per);
         rst_on = m_cfg[2];
         enbuf  = m_cfg[6];
         ld     = (m_pend && lp) || (e && enbuf && rst_on);
         if (e && rst_on) begin
            m_cnt = enbuf ? s_start : m_start; m_up = 1;
         end else if (m_per <= m_start) begin
            m_cnt = m_start; m_up = 1;
         end else if (m_up == 1) begin
            if (m_cnt >= m_per) begin m_cnt = m_cnt - 1; m_up = 0; end
            else m_cnt = m_cnt + 1;
         end else begin
            if (m_cnt <= m_start) begin m_cnt = m_cnt + 1; m_up = 1; end
            else m_cnt = m_cnt - 1;
         end
         if (e && enbuf && !rst_on) m_pend = 1;
         else if (ld)               m_pend = 0;
         if (ld) begin
            m_per = s_per; m_start = s_start; m_cmp[0] = s_cmp[0]; m_cmp[1] = s_cmp[1];
         end
         if (e && m_cfg[5]) m_mask = s_mask;
         if (e && m_cfg[4]) m_inv = s_inv;
         if (e && m_cfg[3]) begin m_oe = s_oe; m_ov = s_ov; end
         if (wr_en) begin
            case (wr_addr)
               4'd0: m_cfg = int'(wr_data[6:0]);
               4'd1: s_per = int'(wr_data);
               4'd2: s_start = int'(wr_data);
               4'd3: s_mask = int'(wr_data[1:0]);
               4'd4: s_inv = int'(wr_data[1:0]);
               4'd5: s_oe = int'(wr_data[1:0]);
               4'd6: s_ov = int'(wr_data[1:0]);
               4'd8: s_cmp[0] = int'(wr_data);
               4'd9: s_cmp[1] = int'(wr_data);
               default: ;
            endcase
         end
         m_tp = hw_trig ? 1 : 0;
      end
   end

   function automatic logic [1:0] model_out();
      logic [1:0] r;
      for (int ch = 0; ch < 2; ch++) begin
         logic b;
         b = (m_cnt < m_cmp[ch]);
         b = b ^ m_inv[ch];
         if (m_oe[ch]) b = m_ov[ch];
         if (m_mask[ch]) b = 1'b0;
         r[ch] = b;
      end
      return r;
   endfunction

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [1:0] exp_o;
         exp_o = model_out();
         vectors++;
         if (pwm_out !== exp_o) begin
            fails++;
            $display("FAIL %s t=%0t pwm_out=%b expected %b", cur_req, $time, pwm_out, exp_o);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input int a, input int d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic pulse_trig();
      @(posedge clk); #2; hw_trig = 1'b1;
      @(posedge clk); #2; hw_trig = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic expect_out(input logic [1:0] e, input string req);
      @(negedge clk);
      vectors++;
      if (pwm_out !== e) begin
         fails++;
         $display("FAIL %s explicit pwm_out=%b expected %b", req, pwm_out, e);
      end
   endtask

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog expired: run still active, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      // R1: reset state, all outputs masked low
      cur_req = "R1";
      idle(4); #2 rst_n = 1'b1;
      expect_out(2'b00, "R1");
      idle(4);

      // R3: shadow writes alone change nothing visible
      cur_req = "R3";
      wr(0, 0); wr(1, 10); wr(2, 2); wr(8, 6); wr(9, 4); wr(3, 0); wr(4, 2);
      idle(20);
      expect_out(2'b00, "R3");

      // R5: immediate groups load on the edge; ch1 inverted, counter idle at 0
      cur_req = "R5";
      wr(0, 'h38);
      pulse_trig();
      expect_out(2'b10, "R5");

      // R9: buffered group not enabled, period stays zero
      cur_req = "R9";
      idle(30);
      expect_out(2'b10, "R9");

      // R7: buffered group enabled but no loading point, no restart
      cur_req = "R7";
      wr(0, 'h78);
      pulse_trig();
      idle(50);
      expect_out(2'b10, "R7");

      // R8: restart loads buffered values and sets counter to start=2
      cur_req = "R8";
      wr(0, 'h7C);
      pulse_trig();
      expect_out(2'b01, "R8");

      // R2: up/down sweep between 2 and 10
      cur_req = "R2";
      idle(40);

      // R6: top loading point, immediate groups disabled
      cur_req = "R6";
      wr(0, 'h42); wr(8, 9);
      idle(3); pulse_trig(); idle(40);
      // R6: bottom loading point
      wr(0, 'h41); wr(8, 3);
      idle(5); pulse_trig(); idle(40);

      // R10: software override forces ch0 high, then mask ch0
      cur_req = "R10";
      wr(5, 1); wr(6, 1); wr(0, 'h08);
      pulse_trig(); idle(20);
      wr(5, 0); wr(3, 1); wr(0, 'h28);
      pulse_trig(); idle(20);

      // R11: unmask before new compare loads; old compare shapes the pulse
      cur_req = "R11";
      wr(8, 12); wr(3, 0); wr(0, 'h62);
      idle(4); pulse_trig(); idle(40);

      // R4: held trigger level starts no further update
      cur_req = "R4";
      wr(0, 'h20);
      @(posedge clk); #2 hw_trig = 1'b1;
      idle(3); wr(3, 3); idle(6);
      #2 hw_trig = 1'b0;
      idle(3);
      pulse_trig();
      expect_out(2'b00, "R4");

      // R2: period not above start: counter holds at start=5
      cur_req = "R2";
      wr(1, 2); wr(2, 5); wr(3, 0); wr(0, 'h64);
      pulse_trig();
      expect_out(2'b11, "R2");
      idle(20);
      expect_out(2'b11, "R2");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule